// File: doc/BRIEF.md
# Lockable Configuration Parameter Register

This block holds the FIFO setup of a disk controller: a FIFO-disable flag, a FIFO threshold and the track number at which write precompensation starts. A configure command loads all three fields at once. A lock command sets or clears a lock bit, and that bit decides what a software reset does to the three fields. When the lock is clear, a software reset puts the defaults back. When the lock is set, the fields survive a software reset. A hardware reset (asynchronous, active low) always clears the lock and restores the defaults.

Every lock command posts one status byte. The byte goes out through a valid/ready handshake and reports the lock value that the command wrote. The command decoder and the FIFO datapath sit outside this block.

Two small state machines shape the behaviour. The parameter bank picks one action per cycle: ACT_HOLD, ACT_LOAD (configure write) or ACT_DEFAULT (software reset while unlocked). The status port has two states, ST_EMPTY and ST_FULL, with these transitions:
- T_POST: ST_EMPTY to ST_FULL on a lock command.
- T_ACCEPT: ST_FULL to ST_EMPTY when ready is high and no lock command arrives.
- T_REPLACE: ST_FULL to ST_FULL on a lock command, which overwrites the byte.
- T_WAIT: ST_FULL to ST_FULL while ready is low.

Top module: `lockable_cfg_reg`

## Requirements
- R1: While hw_rst_n is low, the outputs read: lock_on = 0, fifo_off = 1, fifo_thresh = 0, precomp_trk = 0 and stat_valid = 0.
- R2: A cycle with cfg_we high loads cfg_fifo_off, cfg_thresh and cfg_trk into the outputs at the next clock edge, whether the lock is set or clear. The one exception is R4.
- R3: A cycle with lock_we high copies bit 7 of lock_cmd into lock_on at the next clock edge. Every other bit of lock_cmd is ignored.
- R4: A cycle with sw_reset high while lock_on is 0 restores the three defaults at the next edge. This takes priority over a configure write in the same cycle.
- R5: A cycle with sw_reset high while lock_on is 1 leaves the three fields unchanged, apart from a configure write in the same cycle. A software reset never changes lock_on.
- R6: After a cycle with lock_we high, stat_valid is 1 from the next edge. stat_data has bit 4 equal to the lock value written and all other bits 0.
- R7: While stat_valid is 1 and stat_ready is 0, with no new lock command, stat_valid stays 1 and stat_data stays stable. A cycle with both stat_valid and stat_ready high and no lock command drops stat_valid at the next edge.
- R8: A lock command that arrives while a byte is pending replaces it with the new value. This holds even in a cycle where the old byte is accepted, and stat_valid stays 1.
- R9: When sw_reset and lock_we share a cycle, the software reset is judged by the lock value from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_reset | input | 1 | Software reset request, one cycle per pulse |
| cfg_we | input | 1 | Configure-command write strobe |
| cfg_fifo_off | input | 1 | New FIFO-disable flag |
| cfg_thresh | input | THR_W | New FIFO threshold |
| cfg_trk | input | TRK_W | New precompensation start track |
| lock_we | input | 1 | Lock-command write strobe |
| lock_cmd | input | CMD_W | Lock command byte; bit 7 holds the new lock value |
| stat_ready | input | 1 | Consumer accepts the status byte |
| fifo_off | output | 1 | Current FIFO-disable flag |
| fifo_thresh | output | THR_W | Current FIFO threshold |
| precomp_trk | output | TRK_W | Current precompensation start track |
| lock_on | output | 1 | Current lock bit |
| stat_valid | output | 1 | Status byte pending |
| stat_data | output | CMD_W | Status byte; bit 4 holds the lock value |

## Verification
The bench builds the block with its default parameters: a 4-bit threshold, an 8-bit track, an 8-bit command byte and the default values 1, 0 and 0. With 4 and 8 bits, random configure values differ from the defaults almost every time, so a wrongly applied or wrongly skipped software reset shows up at the outputs. Random traffic then mixes lock commands, software resets and a stalling consumer in the same cycles. This covers the collisions named in R4, R8 and R9 many times over.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
    // Action the parameter bank takes in a cycle
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_LOAD    = 2'd1,
        ACT_DEFAULT = 2'd2
    } bank_act_e;

    // Status port occupancy
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stat_state_e;
endpackage

// File: rtl/cfgreg_param_bank.sv
module cfgreg_param_bank
    import cfgreg_pkg::*;
#(
    parameter int unsigned THR_W   = 4,
    parameter int unsigned TRK_W   = 8,
    parameter bit          DEF_OFF = 1'b1,
    parameter int unsigned DEF_THR = 0,
    parameter int unsigned DEF_TRK = 0
) (
    input  logic             clk,
    input  logic             hw_rst_n,
    input  logic             sw_reset,
    input  logic             lock_q,
    input  logic             cfg_we,
    input  logic             cfg_fifo_off,
    input  logic [THR_W-1:0] cfg_thresh,
    input  logic [TRK_W-1:0] cfg_trk,
    output logic             fifo_off,
    output logic [THR_W-1:0] fifo_thresh,
    output logic [TRK_W-1:0] precomp_trk
);
    localparam logic [THR_W-1:0] THR_RST = THR_W'(DEF_THR);
    localparam logic [TRK_W-1:0] TRK_RST = TRK_W'(DEF_TRK);

    bank_act_e act;

    always_comb begin
        if (sw_reset && !lock_q) begin
            act = ACT_DEFAULT;
        end else if (cfg_we) begin
            act = ACT_LOAD;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            fifo_off    <= DEF_OFF;
            fifo_thresh <= THR_RST;
            precomp_trk <= TRK_RST;
        end else begin
            unique case (act)
                ACT_DEFAULT: begin
                    fifo_off    <= DEF_OFF;
                    fifo_thresh <= THR_RST;
                    precomp_trk <= TRK_RST;
                end
                ACT_LOAD: begin
                    fifo_off    <= cfg_fifo_off;
                    fifo_thresh <= cfg_thresh;
                    precomp_trk <= cfg_trk;
                end
                default: begin
                end
            endcase
        end
    end

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (cfg_we && !(sw_reset && !lock_q)) |=>
        (fifo_off == $past(cfg_fifo_off) && fifo_thresh == $past(cfg_thresh)
         && precomp_trk == $past(cfg_trk)));

    // R4
    unlocked_reset_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (sw_reset && !lock_q) |=>
        (fifo_off == DEF_OFF && fifo_thresh == THR_RST && precomp_trk == TRK_RST));

    // R5
    locked_keep_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (sw_reset && lock_q && !cfg_we) |=>
        ($stable(fifo_off) && $stable(fifo_thresh) && $stable(precomp_trk)));
endmodule

// File: rtl/cfgreg_lock_bit.sv
module cfgreg_lock_bit #(
    parameter int unsigned CMD_W   = 8,
    parameter int unsigned CMD_BIT = 7
) (
    input  logic             clk,
    input  logic             hw_rst_n,
    input  logic             sw_reset,
    input  logic             lock_we,
    input  logic [CMD_W-1:0] lock_cmd,
    output logic             lock_q
);
    logic new_val;
    assign new_val = lock_cmd[CMD_BIT];

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            lock_q <= 1'b0;
        end else if (lock_we) begin
            lock_q <= new_val;
        end
    end

    // R3
    lock_load_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        lock_we |=> (lock_q == $past(lock_cmd[CMD_BIT])));

    // R5
    lock_sw_keep_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (sw_reset && !lock_we) |=> $stable(lock_q));
endmodule

// File: rtl/cfgreg_status_fsm.sv
module cfgreg_status_fsm
    import cfgreg_pkg::*;
#(
    parameter int unsigned CMD_W    = 8,
    parameter int unsigned CMD_BIT  = 7,
    parameter int unsigned STAT_BIT = 4
) (
    input  logic             clk,
    input  logic             hw_rst_n,
    input  logic             lock_we,
    input  logic [CMD_W-1:0] lock_cmd,
    input  logic             stat_ready,
    output logic             stat_valid,
    output logic [CMD_W-1:0] stat_data
);
    localparam logic [CMD_W-1:0] STAT_MASK = CMD_W'(1) << STAT_BIT;

    stat_state_e state, state_nx;

    // Next-state selection: T_POST, T_REPLACE, T_ACCEPT, T_WAIT
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (lock_we) state_nx = ST_FULL;
            ST_FULL: begin
                if (lock_we) begin
                    state_nx = ST_FULL;
                end else if (stat_ready) begin
                    state_nx = ST_EMPTY;
                end
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    // Output register: status byte captured on every lock command
    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            stat_data <= '0;
        end else if (lock_we) begin
            stat_data <= lock_cmd[CMD_BIT] ? STAT_MASK : '0;
        end
    end

    assign stat_valid = (state == ST_FULL);

    // R6
    stat_post_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        lock_we |=> (stat_valid && stat_data[STAT_BIT] == $past(lock_cmd[CMD_BIT])));

    // R6
    stat_clean_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        stat_valid |-> ((stat_data & ~STAT_MASK) == '0));

    // R7
    stat_hold_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (stat_valid && !stat_ready && !lock_we) |=> (stat_valid && $stable(stat_data)));

    // R7
    stat_drop_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (stat_valid && stat_ready && !lock_we) |=> !stat_valid);
endmodule

// File: rtl/lockable_cfg_reg.sv
module lockable_cfg_reg #(
    parameter int unsigned THR_W    = 4,
    parameter int unsigned TRK_W    = 8,
    parameter int unsigned CMD_W    = 8,
    parameter int unsigned CMD_BIT  = 7,
    parameter int unsigned STAT_BIT = 4,
    parameter bit          DEF_OFF  = 1'b1,
    parameter int unsigned DEF_THR  = 0,
    parameter int unsigned DEF_TRK  = 0
) (
    input  logic             clk,
    input  logic             hw_rst_n,
    input  logic             sw_reset,
    input  logic             cfg_we,
    input  logic             cfg_fifo_off,
    input  logic [THR_W-1:0] cfg_thresh,
    input  logic [TRK_W-1:0] cfg_trk,
    input  logic             lock_we,
    input  logic [CMD_W-1:0] lock_cmd,
    input  logic             stat_ready,
    output logic             fifo_off,
    output logic [THR_W-1:0] fifo_thresh,
    output logic [TRK_W-1:0] precomp_trk,
    output logic             lock_on,
    output logic             stat_valid,
    output logic [CMD_W-1:0] stat_data
);
    logic lock_q;

    cfgreg_lock_bit #(
        .CMD_W  (CMD_W),
        .CMD_BIT(CMD_BIT)
    ) u_lock (
        .clk     (clk),
        .hw_rst_n(hw_rst_n),
        .sw_reset(sw_reset),
        .lock_we (lock_we),
        .lock_cmd(lock_cmd),
        .lock_q  (lock_q)
    );

    cfgreg_param_bank #(
        .THR_W  (THR_W),
        .TRK_W  (TRK_W),
        .DEF_OFF(DEF_OFF),
        .DEF_THR(DEF_THR),
        .DEF_TRK(DEF_TRK)
    ) u_bank (
        .clk         (clk),
        .hw_rst_n    (hw_rst_n),
        .sw_reset    (sw_reset),
        .lock_q      (lock_q),
        .cfg_we      (cfg_we),
        .cfg_fifo_off(cfg_fifo_off),
        .cfg_thresh  (cfg_thresh),
        .cfg_trk     (cfg_trk),
        .fifo_off    (fifo_off),
        .fifo_thresh (fifo_thresh),
        .precomp_trk (precomp_trk)
    );

    cfgreg_status_fsm #(
        .CMD_W   (CMD_W),
        .CMD_BIT (CMD_BIT),
        .STAT_BIT(STAT_BIT)
    ) u_stat (
        .clk       (clk),
        .hw_rst_n  (hw_rst_n),
        .lock_we   (lock_we),
        .lock_cmd  (lock_cmd),
        .stat_ready(stat_ready),
        .stat_valid(stat_valid),
        .stat_data (stat_data)
    );

    assign lock_on = lock_q;

    // R9: the software reset uses the lock value from before the cycle
    prior_lock_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (sw_reset && lock_we && !lock_on && !cfg_we) |=>
        (fifo_off == DEF_OFF && fifo_thresh == THR_W'(DEF_THR)
         && precomp_trk == TRK_W'(DEF_TRK)));
endmodule

// File: tb/lockable_cfg_reg_test.sv
module lockable_cfg_reg_test;
    logic       clk = 1'b0;
    logic       hw_rst_n = 1'b0;
    logic       sw_reset = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_fifo_off = 1'b0;
    logic [3:0] cfg_thresh = '0;
    logic [7:0] cfg_trk = '0;
    logic       lock_we = 1'b0;
    logic [7:0] lock_cmd = '0;
    logic       stat_ready = 1'b0;
    logic       fifo_off;
    logic [3:0] fifo_thresh;
    logic [7:0] precomp_trk;
    logic       lock_on;
    logic       stat_valid;
    logic [7:0] stat_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic       e_off;
    logic [3:0] e_thr;
    logic [7:0] e_trk;
    logic       e_lock;
    logic       e_sv;
    logic [7:0] e_sd;

    always #10 clk = ~clk;

    lockable_cfg_reg uut (
        .clk(clk), .hw_rst_n(hw_rst_n), .sw_reset(sw_reset), .cfg_we(cfg_we),
        .cfg_fifo_off(cfg_fifo_off), .cfg_thresh(cfg_thresh), .cfg_trk(cfg_trk),
        .lock_we(lock_we), .lock_cmd(lock_cmd), .stat_ready(stat_ready),
        .fifo_off(fifo_off), .fifo_thresh(fifo_thresh), .precomp_trk(precomp_trk),
        .lock_on(lock_on), .stat_valid(stat_valid), .stat_data(stat_data)
    );

    function automatic logic [7:0] stat_byte(input logic v);
        return v ? 8'h10 : 8'h00;
    endfunction

    task automatic model_defaults();
        e_off = 1'b1; e_thr = '0; e_trk = '0;
        e_lock = 1'b0; e_sv = 1'b0; e_sd = '0;
    endtask

    task automatic check_all(input string tag);
        n_checks++;
        if (fifo_off !== e_off || fifo_thresh !== e_thr || precomp_trk !== e_trk ||
            lock_on !== e_lock || stat_valid !== e_sv || (e_sv && stat_data !== e_sd)) begin
            n_fail++;
            $display("FAIL %s act off=%0d thr=%0d trk=%0d lock=%0d sv=%0d sd=%02h exp off=%0d thr=%0d trk=%0d lock=%0d sv=%0d sd=%02h",
                     tag, fifo_off, fifo_thresh, precomp_trk, lock_on, stat_valid, stat_data,
                     e_off, e_thr, e_trk, e_lock, e_sv, e_sd);
        end
    endtask

    // Drives one cycle at the falling edge, predicts, and returns at the next falling edge
    task automatic cycle(input logic sw, input logic cw, input logic coff,
                         input logic [3:0] cthr, input logic [7:0] ctrk,
                         input logic lw, input logic [7:0] lcmd, input logic rdy);
        sw_reset = sw; cfg_we = cw; cfg_fifo_off = coff; cfg_thresh = cthr;
        cfg_trk = ctrk; lock_we = lw; lock_cmd = lcmd; stat_ready = rdy;
        if (sw && !e_lock) begin
            e_off = 1'b1; e_thr = '0; e_trk = '0;
        end else if (cw) begin
            e_off = coff; e_thr = cthr; e_trk = ctrk;
        end
        if (lw) begin
            e_sv = 1'b1; e_sd = stat_byte(lcmd[7]);
        end else if (e_sv && rdy) begin
            e_sv = 1'b0;
        end
        if (lw) e_lock = lcmd[7];
        @(posedge clk);
        @(negedge clk);
        sw_reset = 1'b0; cfg_we = 1'b0; lock_we = 1'b0;
    endtask

    task automatic idle(input logic rdy);
        cycle(1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 8'h00, rdy);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        model_defaults();
        repeat (3) @(negedge clk);
        check_all("R1 reset state");
        hw_rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        cycle(1'b0, 1'b1, 1'b0, 4'hA, 8'h5C, 1'b0, 8'h00, 1'b0);
        check_all("R2 configure unlocked");
        cycle(1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 8'h00, 1'b0);
        check_all("R4 sw reset unlocked");
        cycle(1'b0, 1'b1, 1'b0, 4'h7, 8'h21, 1'b0, 8'h00, 1'b0);
        cycle(1'b1, 1'b1, 1'b0, 4'h3, 8'h44, 1'b0, 8'h00, 1'b0);
        check_all("R4 sw reset beats configure");

        cycle(1'b0, 1'b1, 1'b0, 4'hC, 8'h90, 1'b0, 8'h00, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 1'b1, 8'h8F, 1'b0);
        check_all("R3 R6 lock set and status");
        idle(1'b0);
        idle(1'b0);
        check_all("R7 status held");
        cycle(1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 8'h00, 1'b0);
        check_all("R5 sw reset locked keeps fields");
        cycle(1'b1, 1'b1, 1'b0, 4'h2, 8'h33, 1'b0, 8'h00, 1'b0);
        check_all("R5 R2 configure during locked sw reset");
        cycle(1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 1'b1, 8'h70, 1'b1);
        check_all("R8 replace on accept cycle");
        idle(1'b1);
        check_all("R7 status accepted");

        cycle(1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 1'b1, 8'h80, 1'b1);
        cycle(1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 1'b1, 8'h00, 1'b0);
        check_all("R9 prior lock set shields reset");
        cycle(1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 1'b1, 8'h80, 1'b0);
        check_all("R9 prior lock clear allows reset");

        for (int i = 0; i < 600; i++) begin
            logic sw, cw, lw, rdy;
            sw  = ($urandom_range(0, 5) == 0);
            cw  = ($urandom_range(0, 2) == 0);
            lw  = ($urandom_range(0, 3) == 0);
            rdy = ($urandom_range(0, 1) == 0);
            cycle(sw, cw, 1'($urandom), 4'($urandom), 8'($urandom), lw, 8'($urandom), rdy);
            check_all("R2/R3/R4/R5/R6/R7/R8/R9 random");
        end

        cycle(1'b0, 1'b1, 1'b0, 4'hF, 8'hEE, 1'b1, 8'h80, 1'b0);
        hw_rst_n = 1'b0;
        model_defaults();
        @(negedge clk);
        check_all("R1 hardware reset mid run");
        hw_rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule